// File: doc/BRIEF.md
# DMA and HDMA Bus Arbiter

This block decides when the bus leaves the CPU and goes to one of two transfer engines. One is a general-purpose block-copy engine that software starts. The other is a per-scanline engine that is armed once per frame and then fired once per visible line. The block turns trigger strobes and channel enable masks into pending requests. It takes the bus when a request is pending. It serves the line engine ahead of the block engine, and lets the line engine interrupt a block copy already in flight.

Entry to a transfer is padded so that it starts on a boundary of an external eight-step phase counter. On exit, the block stalls once more so that the CPU gets the bus back on a whole CPU-cycle boundary. The length of that stall comes from a running count, modulo the CPU cycle length, of the clocks the transfers used. For one cycle after the bus comes back, the block holds a lock that stops NMI and IRQ requests from being sampled. The pending interrupt flags only collect requests, through an OR, while that lock is low.

Top module: `dma_arb_top`

## Requirements
- R1: A pulse on `hdmaInitTrig` drives `hdmaReset` high for exactly one cycle, on the cycle after the pulse. The pulse arms an initialise-mode line-engine request only if `hdmaEnMask` is nonzero. With a zero mask, the bus stays with the CPU.
- R2: A pulse on `hdmaRunTrig` arms a run-mode line-engine request only if `hdmaActMask` is nonzero and `lineIdx < visLines`. Otherwise the pulse is ignored and `busGrant` stays low.
- R3: `busGrant` rises only on the clock after a request has been registered as pending. It stays high until the exit stall ends.
- R4: A pending line-engine request is served before a pending block request. `hdmaGrant` and `dmaGrant` are never high together. A line-engine request that arrives during a block transfer suspends `dmaGrant`, is served, and the block transfer then resumes.
- R5: `alignStall` is high for exactly 2^PHW − `phase` consecutive cycles (8 − phase by default) before every block transfer. The same stall comes before a line-engine transfer when `dmaEnMask` is zero. There is no alignment stall before a line-engine transfer while `dmaEnMask` is nonzero.
- R6: After the last transfer, `resyncStall` is high for exactly L − (U mod L) cycles, and then `busGrant` falls. Here L is `cpuCycLen` and U is the number of alignment and grant cycles since the bus was taken.
- R7: `irqLock` is high for exactly one cycle: the first cycle after `busGrant` falls.
- R8: A cycle with `irqLock` low and `nmiTest` (or `irqTest`) high sets `nmiPend` (or `irqPend`). A cycle with `irqLock` high leaves both flags unchanged. The flags hold until `intAck`. `intPend` is their OR.
- R9: `hdmaModeRun` is 0 for an initialise service and 1 for a run service. It is latched when a line-engine service starts and holds throughout its grant.
- R10: At most one of `alignStall`, `hdmaGrant`, `dmaGrant` and `resyncStall` is high at a time, and only while `busGrant` is high. During a stall, `stallLeft` falls by one each cycle and reads 1 on the last stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdmaInitTrig | input | 1 | Once-per-frame line-engine arm strobe |
| hdmaRunTrig | input | 1 | Once-per-line line-engine fire strobe |
| lineIdx | input | LINEW | Current scanline |
| visLines | input | LINEW | Number of visible scanlines |
| dmaStart | input | 1 | Block-copy start strobe |
| dmaEnMask | input | NCH | Block-copy channel enables |
| hdmaEnMask | input | NCH | Line-engine channel enables |
| hdmaActMask | input | NCH | Line-engine channels still active this frame |
| hdmaDone | input | 1 | Line engine finished its service |
| dmaDone | input | 1 | Block engine finished its copy |
| phase | input | PHW | Current eight-step phase value |
| cpuCycLen | input | CYCW | CPU cycle length in clocks (nonzero) |
| nmiTest | input | 1 | NMI condition this cycle |
| irqTest | input | 1 | IRQ condition this cycle |
| intAck | input | 1 | Clears the pending interrupt flags |
| busGrant | output | 1 | Bus taken from the CPU |
| hdmaGrant | output | 1 | Line engine owns the bus |
| dmaGrant | output | 1 | Block engine owns the bus |
| hdmaModeRun | output | 1 | Line-engine mode: 0 initialise, 1 run |
| alignStall | output | 1 | Entry alignment stall |
| resyncStall | output | 1 | Exit resynchronisation stall |
| stallLeft | output | STALLW | Remaining stall cycles, including the current one |
| hdmaReset | output | 1 | Line-engine channel state reset pulse |
| irqLock | output | 1 | Interrupt sampling lock |
| nmiPend | output | 1 | Collected NMI request |
| irqPend | output | 1 | Collected IRQ request |
| intPend | output | 1 | Either interrupt pending |

## Verification
The embedded properties check the following on every cycle:
- the grants and stalls never overlap, and never appear without `busGrant`;
- the stall counter steps down by one and stays within its bounds;
- the bus is taken only after a request is pending;
- the lock appears right after the bus comes back, and the interrupt flags hold while it is high.

Some behaviour only the bench scenarios can show. One part is the exact lengths of the alignment and resync stalls across every phase value and several CPU cycle lengths. The other is the serving order: line engine first, a suspended block copy that later resumes, and the latched mode.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ALIGN,
    ST_XFER_H,
    ST_XFER_D,
    ST_RESYNC
  } arbState_t;

  // Strobes from control to datapath, one bundle per cycle
  typedef struct packed {
    logic loadAlign;   // load stall counter with the phase padding
    logic loadResync;  // load stall counter with the cycle padding
    logic countUse;    // this cycle is consumed by a takeover
    logic clearUse;    // start of a takeover: clear usage residue
    logic busExit;     // last cycle of the takeover
  } arbStrobe_t;

endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int LINEW = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdmaInitTrig,
  input  logic             hdmaRunTrig,
  input  logic [LINEW-1:0] lineIdx,
  input  logic [LINEW-1:0] visLines,
  input  logic             dmaStart,
  input  logic [NCH-1:0]   dmaEnMask,
  input  logic [NCH-1:0]   hdmaEnMask,
  input  logic [NCH-1:0]   hdmaActMask,
  input  logic             hdmaDone,
  input  logic             dmaDone,
  input  logic             stallLast,
  output arbStrobe_t       strb,
  output logic             busGrant,
  output logic             hdmaGrant,
  output logic             dmaGrant,
  output logic             hdmaModeRun,
  output logic             alignStall,
  output logic             resyncStall,
  output logic             hdmaReset
);

  arbState_t st, stN;
  logic hdmaPend, dmaPend, pendRun;
  logic alignToD, alignToDN;
  logic resumeD, resumeDN;
  logic served, servedN;
  logic consumeH, consumeD, latchMode;
  logic anyDmaEn, anyHdmaEn, anyHdmaAct;
  logic initHit, runHit;

  assign anyDmaEn   = |dmaEnMask;
  assign anyHdmaEn  = |hdmaEnMask;
  assign anyHdmaAct = |hdmaActMask;
  assign initHit    = hdmaInitTrig & anyHdmaEn;
  assign runHit     = hdmaRunTrig & anyHdmaAct & (lineIdx < visLines);

  // Next-state and strobe decode
  always_comb begin
    stN       = st;
    alignToDN = alignToD;
    resumeDN  = resumeD;
    consumeH  = 1'b0;
    consumeD  = 1'b0;
    latchMode = 1'b0;
    strb      = '0;
    unique case (st)
      ST_IDLE: begin
        if (hdmaPend || dmaPend) begin
          stN = ST_SEL;
          strb.clearUse = 1'b1;
        end
      end
      ST_SEL: begin
        if (hdmaPend) begin
          consumeH = 1'b1;
          if (anyHdmaEn) begin
            latchMode = 1'b1;
            if (!anyDmaEn) begin
              stN = ST_ALIGN;
              alignToDN = 1'b0;
              strb.loadAlign = 1'b1;
            end else begin
              stN = ST_XFER_H;
            end
          end
        end else if (dmaPend) begin
          consumeD = 1'b1;
          if (anyDmaEn) begin
            stN = ST_ALIGN;
            alignToDN = 1'b1;
            strb.loadAlign = 1'b1;
          end
        end else if (served) begin
          stN = ST_RESYNC;
          strb.loadResync = 1'b1;
        end else begin
          stN = ST_IDLE;
          strb.busExit = 1'b1;
        end
      end
      ST_ALIGN: begin
        strb.countUse = 1'b1;
        if (stallLast) stN = alignToD ? ST_XFER_D : ST_XFER_H;
      end
      ST_XFER_H: begin
        strb.countUse = 1'b1;
        if (hdmaDone) begin
          if (resumeD) begin
            stN = ST_XFER_D;
            resumeDN = 1'b0;
          end else if (anyDmaEn) begin
            stN = ST_SEL;
          end else begin
            stN = ST_RESYNC;
            strb.loadResync = 1'b1;
          end
        end
      end
      ST_XFER_D: begin
        strb.countUse = 1'b1;
        if (dmaDone) begin
          stN = ST_RESYNC;
          strb.loadResync = 1'b1;
        end else if (hdmaPend && anyHdmaEn) begin
          consumeH  = 1'b1;
          latchMode = 1'b1;
          resumeDN  = 1'b1;
          stN       = ST_XFER_H;
        end
      end
      ST_RESYNC: begin
        if (stallLast) begin
          stN = ST_IDLE;
          strb.busExit = 1'b1;
        end
      end
      default: stN = ST_IDLE;
    endcase
  end

  assign servedN = (st == ST_IDLE) ? 1'b0 :
                   (served | (st == ST_ALIGN) | (st == ST_XFER_H) | (st == ST_XFER_D));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st          <= ST_IDLE;
      alignToD    <= 1'b0;
      resumeD     <= 1'b0;
      served      <= 1'b0;
      hdmaPend    <= 1'b0;
      dmaPend     <= 1'b0;
      pendRun     <= 1'b0;
      hdmaModeRun <= 1'b0;
      hdmaReset   <= 1'b0;
    end else begin
      st        <= stN;
      alignToD  <= alignToDN;
      resumeD   <= resumeDN;
      served    <= servedN;
      hdmaReset <= hdmaInitTrig;
      // A fresh trigger wins over a same-cycle consumption
      if (initHit || runHit) hdmaPend <= 1'b1;
      else if (consumeH)     hdmaPend <= 1'b0;
      if (initHit)           pendRun <= 1'b0;
      else if (runHit)       pendRun <= 1'b1;
      if (dmaStart)          dmaPend <= 1'b1;
      else if (consumeD)     dmaPend <= 1'b0;
      if (latchMode)         hdmaModeRun <= pendRun;
    end
  end

  assign busGrant    = (st != ST_IDLE);
  assign hdmaGrant   = (st == ST_XFER_H);
  assign dmaGrant    = (st == ST_XFER_D);
  assign alignStall  = (st == ST_ALIGN);
  assign resyncStall = (st == ST_RESYNC);

  // R3: the bus is only taken after a request was registered
  p_take_needs_pend_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrant) |-> $past(hdmaPend || dmaPend));

  // R9: mode holds steady for the whole of one line-engine grant
  p_mode_steady_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hdmaGrant && $past(hdmaGrant)) |-> $stable(hdmaModeRun));

  // R4: grants are exclusive
  p_grant_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(hdmaGrant && dmaGrant));

endmodule

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int PHW    = 3,
  parameter int CYCW   = 4,
  parameter int STALLW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strb,
  input  logic [PHW-1:0]    phase,
  input  logic [CYCW-1:0]   cpuCycLen,
  input  logic              nmiTest,
  input  logic              irqTest,
  input  logic              intAck,
  output logic [STALLW-1:0] stallLeft,
  output logic              stallLast,
  output logic              irqLock,
  output logic              nmiPend,
  output logic              irqPend
);

  localparam int ALIGN_SPAN = 1 << PHW;

  logic [CYCW-1:0] residue, residueN;
  logic [CYCW:0]   residueInc;

  // Running usage count kept modulo the CPU cycle length
  assign residueInc = {1'b0, residue} + (CYCW+1)'(1);

  always_comb begin
    residueN = residue;
    if (strb.clearUse) begin
      residueN = '0;
    end else if (strb.countUse) begin
      if (residueInc >= {1'b0, cpuCycLen}) residueN = '0;
      else residueN = residueInc[CYCW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      residue   <= '0;
      stallLeft <= '0;
      irqLock   <= 1'b0;
      nmiPend   <= 1'b0;
      irqPend   <= 1'b0;
    end else begin
      residue <= residueN;
      if (strb.loadAlign)
        stallLeft <= STALLW'(ALIGN_SPAN) - STALLW'(phase);
      else if (strb.loadResync)
        stallLeft <= STALLW'(cpuCycLen) - STALLW'(residueN);
      else if (stallLeft != '0)
        stallLeft <= stallLeft - STALLW'(1);
      irqLock <= strb.busExit;
      nmiPend <= (nmiPend & ~intAck) | (nmiTest & ~irqLock);
      irqPend <= (irqPend & ~intAck) | (irqTest & ~irqLock);
    end
  end

  assign stallLast = (stallLeft == STALLW'(1));

  // R8: while locked and not acknowledged the flags do not move
  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqLock && !intAck) |=> (nmiPend == $past(nmiPend)) && (irqPend == $past(irqPend)));

  // R8: an unlocked request is collected
  p_collect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!irqLock && nmiTest) |=> nmiPend);

  // R6: the usage residue stays below the cycle length
  p_residue_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuCycLen != '0 && $stable(cpuCycLen)) |-> (residue < cpuCycLen));

endmodule

// File: rtl/dma_arb_top.sv
module dma_arb_top
  import dma_arb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int PHW   = 3,
  parameter int CYCW  = 4,
  parameter int LINEW = 9,
  localparam int STALLW = ((PHW + 1) > CYCW) ? (PHW + 1) : CYCW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdmaInitTrig,
  input  logic              hdmaRunTrig,
  input  logic [LINEW-1:0]  lineIdx,
  input  logic [LINEW-1:0]  visLines,
  input  logic              dmaStart,
  input  logic [NCH-1:0]    dmaEnMask,
  input  logic [NCH-1:0]    hdmaEnMask,
  input  logic [NCH-1:0]    hdmaActMask,
  input  logic              hdmaDone,
  input  logic              dmaDone,
  input  logic [PHW-1:0]    phase,
  input  logic [CYCW-1:0]   cpuCycLen,
  input  logic              nmiTest,
  input  logic              irqTest,
  input  logic              intAck,
  output logic              busGrant,
  output logic              hdmaGrant,
  output logic              dmaGrant,
  output logic              hdmaModeRun,
  output logic              alignStall,
  output logic              resyncStall,
  output logic [STALLW-1:0] stallLeft,
  output logic              hdmaReset,
  output logic              irqLock,
  output logic              nmiPend,
  output logic              irqPend,
  output logic              intPend
);

  localparam int ALIGN_SPAN = 1 << PHW;

  arbStrobe_t strb;
  logic       stallLast;

  dma_arb_ctrl #(.NCH(NCH), .LINEW(LINEW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hdmaInitTrig(hdmaInitTrig), .hdmaRunTrig(hdmaRunTrig),
    .lineIdx(lineIdx), .visLines(visLines), .dmaStart(dmaStart),
    .dmaEnMask(dmaEnMask), .hdmaEnMask(hdmaEnMask), .hdmaActMask(hdmaActMask),
    .hdmaDone(hdmaDone), .dmaDone(dmaDone), .stallLast(stallLast),
    .strb(strb), .busGrant(busGrant), .hdmaGrant(hdmaGrant), .dmaGrant(dmaGrant),
    .hdmaModeRun(hdmaModeRun), .alignStall(alignStall), .resyncStall(resyncStall),
    .hdmaReset(hdmaReset)
  );

  dma_arb_dp #(.PHW(PHW), .CYCW(CYCW), .STALLW(STALLW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .phase(phase), .cpuCycLen(cpuCycLen),
    .nmiTest(nmiTest), .irqTest(irqTest), .intAck(intAck),
    .stallLeft(stallLeft), .stallLast(stallLast), .irqLock(irqLock),
    .nmiPend(nmiPend), .irqPend(irqPend)
  );

  assign intPend = nmiPend | irqPend;

  // R10: grants and stalls exclusive and only under busGrant
  p_one_owner_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({alignStall, hdmaGrant, dmaGrant, resyncStall}) &&
    (!(alignStall || hdmaGrant || dmaGrant || resyncStall) || busGrant));

  // R10: stall counter steps down by one
  p_stall_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (alignStall && stallLeft > STALLW'(1)) |=> alignStall && (stallLeft == $past(stallLeft) - STALLW'(1)));

  // R5: alignment stall stays within one phase span
  p_align_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    alignStall |-> (stallLeft >= STALLW'(1)) && (stallLeft <= STALLW'(ALIGN_SPAN)));

  // R6: resync stall never exceeds one CPU cycle
  p_resync_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    resyncStall |-> (stallLeft >= STALLW'(1)) && (stallLeft <= STALLW'(cpuCycLen)));

  // R7: lock follows the bus release
  p_lock_on_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busGrant) |-> irqLock);

  p_lock_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqLock |-> !busGrant);

endmodule

// File: tb/sim_dma_arb_top.sv
`timescale 1ns/1ps
module sim_dma_arb_top;
  localparam int NCH = 8, PHW = 3, CYCW = 4, LINEW = 9, STALLW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdmaInitTrig = 0, hdmaRunTrig = 0, dmaStart = 0;
  logic [LINEW-1:0] lineIdx = 9'd10, visLines = 9'd224;
  logic [NCH-1:0] dmaEnMask = '0, hdmaEnMask = '0, hdmaActMask = '0;
  logic hdmaDone = 0, dmaDone = 0;
  logic [PHW-1:0] phase = '0;
  logic [CYCW-1:0] cpuCycLen = 4'd8;
  logic nmiTest = 0, irqTest = 0, intAck = 0;
  logic busGrant, hdmaGrant, dmaGrant, hdmaModeRun, alignStall, resyncStall;
  logic [STALLW-1:0] stallLeft;
  logic hdmaReset, irqLock, nmiPend, irqPend, intPend;

  dma_arb_top #(.NCH(NCH), .PHW(PHW), .CYCW(CYCW), .LINEW(LINEW)) u0 (
    .clk(clk), .rstN(rstN), .hdmaInitTrig(hdmaInitTrig), .hdmaRunTrig(hdmaRunTrig),
    .lineIdx(lineIdx), .visLines(visLines), .dmaStart(dmaStart),
    .dmaEnMask(dmaEnMask), .hdmaEnMask(hdmaEnMask), .hdmaActMask(hdmaActMask),
    .hdmaDone(hdmaDone), .dmaDone(dmaDone), .phase(phase), .cpuCycLen(cpuCycLen),
    .nmiTest(nmiTest), .irqTest(irqTest), .intAck(intAck),
    .busGrant(busGrant), .hdmaGrant(hdmaGrant), .dmaGrant(dmaGrant),
    .hdmaModeRun(hdmaModeRun), .alignStall(alignStall), .resyncStall(resyncStall),
    .stallLeft(stallLeft), .hdmaReset(hdmaReset), .irqLock(irqLock),
    .nmiPend(nmiPend), .irqPend(irqPend), .intPend(intPend)
  );

  always #10 clk = ~clk;

  int nTests = 0, nFail = 0, cyc = 0;
  int hLen = 1, dLen = 1, hCnt = 0, dCnt = 0;
  int alignN, xferN, resyncN, segs, lastSeg, firstMode, busN, trigAt;
  bit lockAtEnd, timedOut;

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  // Mock transfer engines
  always @(negedge clk) begin
    if (!busGrant) begin
      hCnt = 0; dCnt = 0; hdmaDone = 0; dmaDone = 0;
    end else begin
      if (hdmaGrant) begin hCnt++; hdmaDone = (hCnt == hLen); end
      else begin hCnt = 0; hdmaDone = 0; end
      if (dmaGrant) begin dCnt++; dmaDone = (dCnt == dLen); end
      else dmaDone = 0;
    end
  end

  task automatic pulseSig(input int which);
    if (which == 0) dmaStart = 1;
    if (which == 1) hdmaInitTrig = 1;
    if (which == 2) hdmaRunTrig = 1;
    if (which == 3) begin dmaStart = 1; hdmaInitTrig = 1; end
    @(negedge clk);
    dmaStart = 0; hdmaInitTrig = 0; hdmaRunTrig = 0;
  endtask

  // Observe one takeover; returns at the first negedge with busGrant low
  task automatic episode();
    int w = 0, dSeen = 0;
    alignN = 0; xferN = 0; resyncN = 0; segs = 0; lastSeg = 0; firstMode = -1;
    timedOut = 0;
    while (!busGrant && w < 20) begin @(negedge clk); w++; end
    while (busGrant && w < 400) begin
      hdmaRunTrig = 0;
      if (alignStall) alignN++;
      if (resyncStall) resyncN++;
      if (hdmaGrant) begin
        xferN++;
        if (lastSeg != 1) begin segs = segs * 4 + 1; lastSeg = 1; end
        if (firstMode < 0) firstMode = hdmaModeRun;
      end
      if (dmaGrant) begin
        xferN++; dSeen++;
        if (lastSeg != 2) begin segs = segs * 4 + 2; lastSeg = 2; end
        if (trigAt > 0 && dSeen == trigAt) hdmaRunTrig = 1;
      end
      @(negedge clk); w++;
    end
    hdmaRunTrig = 0;
    if (busGrant || w >= 400) timedOut = 1;
    lockAtEnd = irqLock;
  endtask

  function automatic int resyncExp(input int used, input int L);
    return L - (used % L);
  endfunction

  int lens[3] = '{6, 8, 12};

  initial begin
    trigAt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // Reset state
    chk("R3 reset busGrant", busGrant, 0);
    chk("R7 reset irqLock", irqLock, 0);
    chk("R8 reset intPend", intPend, 0);
    chk("R10 reset grants", {alignStall, hdmaGrant, dmaGrant, resyncStall}, 0);

    // Block copy sweep: R3 R5 R6 R7 R10
    dmaEnMask = 8'h01; hdmaEnMask = '0;
    for (int li = 0; li < 3; li++) begin
      for (int ph = 0; ph < 8; ph++) begin
        for (int dl = 1; dl <= 4; dl++) begin
          cpuCycLen = CYCW'(lens[li]); phase = PHW'(ph); dLen = dl;
          pulseSig(0);
          episode();
          chk("R3 episode ends", timedOut, 0);
          chk("R5 align before block copy", alignN, 8 - ph);
          chk("R4 block grant length", xferN, dl);
          chk("R6 resync length", resyncN, resyncExp(8 - ph + dl, lens[li]));
          chk("R7 lock at release", lockAtEnd, 1);
          @(negedge clk);
          chk("R7 lock one cycle", irqLock, 0);
        end
      end
    end

    // Line engine initialise with no block channels: R1 R5 R6 R9
    dmaEnMask = '0; hdmaEnMask = 8'h03; hLen = 2;
    for (int li = 0; li < 3; li++) begin
      for (int ph = 0; ph < 8; ph++) begin
        cpuCycLen = CYCW'(lens[li]); phase = PHW'(ph);
        hdmaInitTrig = 1;
        @(negedge clk);
        hdmaInitTrig = 0;
        chk("R1 hdmaReset pulse", hdmaReset, 1);
        episode();
        chk("R5 align before line engine", alignN, 8 - ph);
        chk("R9 initialise mode", firstMode, 0);
        chk("R6 resync after line engine", resyncN, resyncExp(8 - ph + 2, lens[li]));
        @(negedge clk);
        chk("R1 hdmaReset single", hdmaReset, 0);
      end
    end

    // Run trigger honoured: R2 R9
    cpuCycLen = 4'd8; phase = 3'd5; hdmaActMask = 8'h01; lineIdx = 9'd100;
    pulseSig(2);
    episode();
    chk("R2 run trigger served", xferN, 2);
    chk("R9 run mode", firstMode, 1);

    // Run trigger ignored beyond visible lines, or with no active channel: R2
    lineIdx = visLines;
    pulseSig(2);
    busN = 0;
    repeat (12) begin if (busGrant) busN++; @(negedge clk); end
    chk("R2 run ignored past visible", busN, 0);
    lineIdx = 9'd50; hdmaActMask = '0;
    pulseSig(2);
    busN = 0;
    repeat (12) begin if (busGrant) busN++; @(negedge clk); end
    chk("R2 run ignored no active", busN, 0);

    // Init with no enabled channel: reset pulse only (R1)
    hdmaEnMask = '0;
    hdmaInitTrig = 1;
    @(negedge clk);
    hdmaInitTrig = 0;
    chk("R1 reset pulse without enables", hdmaReset, 1);
    busN = 0;
    repeat (12) begin if (busGrant) busN++; @(negedge clk); end
    chk("R1 no takeover without enables", busN, 0);

    // Both pending: line engine first, no align before it (R4 R5 R6)
    dmaEnMask = 8'h01; hdmaEnMask = 8'h01; hLen = 3; dLen = 4;
    for (int ph = 0; ph < 8; ph++) begin
      phase = PHW'(ph); cpuCycLen = 4'd6;
      pulseSig(3);
      episode();
      chk("R4 line engine before block", segs, 6);
      chk("R5 single align for block", alignN, 8 - ph);
      chk("R6 resync combined", resyncN, resyncExp(8 - ph + 7, 6));
    end

    // Pre-emption of a running block copy (R4 R9)
    hdmaActMask = 8'h01; lineIdx = 9'd20; dLen = 8; hLen = 2; phase = 3'd2; cpuCycLen = 4'd12;
    trigAt = 3;
    pulseSig(0);
    episode();
    trigAt = 0;
    chk("R4 block suspended then resumed", segs, 38);
    chk("R4 total grant cycles", xferN, 10);
    chk("R9 run mode on pre-emption", firstMode, 1);
    chk("R6 resync after pre-emption", resyncN, resyncExp(6 + 10, 12));

    // Interrupt collection and lock (R8)
    dmaEnMask = 8'h01; hdmaEnMask = '0; dLen = 2; phase = 3'd0; cpuCycLen = 4'd8;
    pulseSig(0);
    episode();
    chk("R7 lock before interrupt test", lockAtEnd, 1);
    nmiTest = 1; irqTest = 1;
    @(negedge clk);
    nmiTest = 0; irqTest = 0;
    chk("R8 nmi blocked under lock", nmiPend, 0);
    chk("R8 irq blocked under lock", irqPend, 0);
    nmiTest = 1;
    @(negedge clk);
    nmiTest = 0;
    chk("R8 nmi collected", nmiPend, 1);
    chk("R8 intPend follows", intPend, 1);
    irqTest = 1;
    @(negedge clk);
    irqTest = 0;
    chk("R8 irq collected", irqPend, 1);
    chk("R8 nmi held", nmiPend, 1);
    repeat (3) @(negedge clk);
    chk("R8 flags hold", {nmiPend, irqPend}, 3);
    intAck = 1;
    @(negedge clk);
    intAck = 0;
    chk("R8 ack clears", {nmiPend, irqPend, intPend}, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule